// File: doc/BRIEF.md
# Linked-List Descriptor Copy Engine

This block copies memory to memory under the control of a chain of descriptors that software builds in system memory. Each descriptor takes up a 64-byte-aligned slot. It gives a link to the following slot, a source address, a destination address and a byte count. The engine reads those fields over its memory master port. It then moves the bytes one 32-bit word per beat and writes a completion or error word back into the slot. After that it follows the link. It stops once it has finished the slot whose address matches the programmed last-slot register.

Writes are posted, so several data writes may wait for their responses while the next word is read. Between two slots, however, the engine holds a completion barrier. No read for a slot is issued until every write of the slot before it, including its status word, has been acknowledged. This lets a short slot that loads an address-translation register come safely before the bulk slot that depends on that register.

Software uses a small register port. It sets a run bit, loads the first-slot pointer, and starts the walk by writing the last-slot pointer. It watches an idle flag and a one-cycle finish pulse, and it reads sticky error bits that halt the engine.

Top module: `sgdma_engine`

## Requirements
- R1: After reset the engine is idle, issues no memory request, and the register port reads control 0x00 = 0, status 0x04 = 0x1, first-slot pointer 0x08 = 0 and last-slot pointer 0x10 = 0.
- R2: Slot pointers are 64-byte aligned. Address bits [5:0] of the first-slot and last-slot registers always read as zero. The engine reads only the words at slot offsets 0x00 (link), 0x08 (source), 0x10 (destination) and 0x18 (count, low LEN_W bits), and never reads offsets 0x04, 0x0C, 0x14 or 0x1C.
- R3: A count that is a multiple of 4 is copied as count/4 word reads at ascending source addresses, each followed by a word write at the matching destination address. Counts of 8 and 4096 are supported. A count of 0 moves no data.
- R4: Once a slot's data writes have all been acknowledged, the engine writes that slot's word at offset 0x1C. A clean slot gets bit 31 set and the byte count in the low bits.
- R5: The first read of a slot is never issued while any write of the previous slot, including its status word, still lacks a response.
- R6: The engine walks from the first-slot pointer along the links up to and including the slot equal to the last-slot pointer. It never reads the slot beyond it. Afterwards the first-slot register holds the last slot's link.
- R7: The idle flag (status bit 0) is low while a walk runs. After the last slot's status write is acknowledged, the idle flag rises and a one-cycle finish pulse is given in that same cycle.
- R8: An error response to a data read or data write stops the copy. The slot's status word is written as 0x40000000, status bit 1 is set, the engine goes idle without a finish pulse, and the first-slot register keeps the failing slot.
- R9: A count that is not a multiple of 4 causes no data access. The slot's status word is written as 0x20000000 and status bit 2 is set.
- R10: An error response to a slot field read stops the engine with no write at all and sets status bit 1.
- R11: A walk starts only when the last-slot register is written while control bit 0 (run) is 1, the engine is idle and status bits 1 and 2 are clear. Writes to either pointer register while a walk runs are ignored.
- R12: Writing control with bit 1 set clears status bits 1 and 2. Bit 1 is not stored, and bit 0 keeps the written run value.
- R13: At most one read and at most MAX_OUT writes are outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| m_req | output | 1 | Memory request valid |
| m_we | output | 1 | Request is a write |
| m_addr | output | AW | Request byte address |
| m_wdata | output | 32 | Write data |
| m_ready | input | 1 | Request accepted this cycle |
| m_rvalid | input | 1 | Read data return |
| m_rdata | input | 32 | Read data |
| m_rerr | input | 1 | Error flag with m_rvalid |
| m_bvalid | input | 1 | Write response |
| m_berr | input | 1 | Error flag with m_bvalid |
| idle | output | 1 | Engine has no walk in progress |
| done | output | 1 | One-cycle pulse when a walk ends cleanly |

## Verification
A wrong outstanding-write count shows up at the ports within a slot in one of two ways. Either a field read of the next slot goes out while a write response is still owed, or the status word is written before the data responses have all come back. A memory model that randomises acceptance and response delay catches either case at the moment of that read or write. Misrouted slot fields show up at the end of the same slot, as wrong destination contents or a wrong status word. A wrong link or a wrong last-slot comparison shows up as a read of a slot past the tail, or as a first-slot register value that does not match the tail's link. A lost error flag shows up once the walk ends: as a finish pulse or a later slot fetch where the engine should have halted.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

   typedef enum logic [3:0] {
      DS_IDLE, DS_FRD, DS_FWT, DS_CHK, DS_CRD,
      DS_CWT,  DS_CWR, DS_DRN, DS_SWR, DS_SWT
   } eng_state_t;

   // register byte addresses
   localparam logic [5:0] RA_CTRL = 6'h00;
   localparam logic [5:0] RA_STAT = 6'h04;
   localparam logic [5:0] RA_CUR  = 6'h08;
   localparam logic [5:0] RA_TAIL = 6'h10;

   // slot status word offset and codes
   localparam logic [5:0]  OFF_STAT  = 6'h1C;
   localparam logic [31:0] SW_OK     = 32'h8000_0000;
   localparam logic [31:0] SW_SLVERR = 32'h4000_0000;
   localparam logic [31:0] SW_INTERR = 32'h2000_0000;

endpackage

// File: rtl/sgdma_wtrack.sv
module sgdma_wtrack #(
   parameter int MAX_OUT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic zero,
   output logic full
);
   localparam int CW = $clog2(MAX_OUT + 1);

   if (MAX_OUT == 1) begin : g_flag
      logic busy_q;
      always_ff @(posedge clk) begin
         if (!rst_n)   busy_q <= 1'b0;
         else if (inc) busy_q <= 1'b1;
         else if (dec) busy_q <= 1'b0;
      end
      assign zero = !busy_q;
      assign full = busy_q;
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) cnt_q <= '0;
         else        cnt_q <= cnt_q + CW'(inc) - CW'(dec);
      end
      assign zero = (cnt_q == '0);
      assign full = (cnt_q == CW'(MAX_OUT));
   end

   // R13
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> !full || dec);
   // R13
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> !zero);

endmodule

// File: rtl/sgdma_regs.sv
module sgdma_regs
   import sgdma_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [5:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          eng_idle,
   input  logic          cur_ld,
   input  logic [AW-1:0] cur_nxt,
   input  logic          err_slv_set,
   input  logic          err_int_set,
   output logic          start,
   output logic [AW-1:0] cur_ptr,
   output logic [AW-1:0] tail_ptr
);
   logic          run_q, eslv_q, eint_q;
   logic [AW-1:0] cur_q, tail_q, wr_ptr;
   logic          wr_ctrl, wr_cur, wr_tail;
   logic          unused_wbits;

   assign wr_ctrl      = reg_we && (reg_addr == RA_CTRL);
   assign wr_cur       = reg_we && (reg_addr == RA_CUR);
   assign wr_tail      = reg_we && (reg_addr == RA_TAIL);
   assign wr_ptr       = {reg_wdata[AW-1:6], 6'b0};
   assign unused_wbits = ^reg_wdata[5:2];
   assign start        = wr_tail && run_q && eng_idle && !eslv_q && !eint_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         eslv_q <= 1'b0;
         eint_q <= 1'b0;
         cur_q  <= '0;
         tail_q <= '0;
      end else begin
         if (wr_ctrl) run_q <= reg_wdata[0];
         if (wr_ctrl && reg_wdata[1]) begin
            eslv_q <= 1'b0;
            eint_q <= 1'b0;
         end
         if (err_slv_set) eslv_q <= 1'b1;
         if (err_int_set) eint_q <= 1'b1;
         if (wr_tail && eng_idle) tail_q <= wr_ptr;
         if (cur_ld)                    cur_q <= cur_nxt;
         else if (wr_cur && eng_idle)   cur_q <= wr_ptr;
      end
   end

   always_comb begin
      unique case (reg_addr)
         RA_CTRL: reg_rdata = {31'b0, run_q};
         RA_STAT: reg_rdata = {29'b0, eint_q, eslv_q, eng_idle};
         RA_CUR:  reg_rdata = 32'(cur_q);
         RA_TAIL: reg_rdata = 32'(tail_q);
         default: reg_rdata = '0;
      endcase
   end

   assign cur_ptr  = cur_q;
   assign tail_ptr = tail_q;

   // R2
   cur_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_ld |-> cur_nxt[5:0] == 6'b0);
   // R11
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !eng_idle);

endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
   import sgdma_pkg::*;
#(
   parameter int AW    = 32,
   parameter int LEN_W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] cur_ptr,
   input  logic [AW-1:0] tail_ptr,
   output logic          m_req,
   output logic          m_we,
   output logic [AW-1:0] m_addr,
   output logic [31:0]   m_wdata,
   input  logic          m_ready,
   input  logic          m_rvalid,
   input  logic [31:0]   m_rdata,
   input  logic          m_rerr,
   input  logic          m_bvalid,
   input  logic          m_berr,
   input  logic          w_zero,
   input  logic          w_full,
   output logic          w_inc,
   output logic          cur_ld,
   output logic [AW-1:0] cur_nxt,
   output logic          err_slv_set,
   output logic          err_int_set,
   output logic          idle,
   output logic          done
);
   localparam int WN = LEN_W - 2;

   eng_state_t     st;
   logic [1:0]     fidx;
   logic [AW-1:0]  nxt_q, src_q, dst_q;
   logic [LEN_W-1:0] ctl_q;
   logic [WN-1:0]  left_q;
   logic [31:0]    data_q, stat_word;
   logic           d_slv, d_int, done_q, accept, swt_end;

   assign stat_word = d_slv ? SW_SLVERR : d_int ? SW_INTERR : (SW_OK | 32'(ctl_q));

   always_comb begin
      m_req   = 1'b0;
      m_we    = 1'b0;
      m_addr  = '0;
      m_wdata = '0;
      unique case (st)
         DS_FRD: begin
            m_req  = 1'b1;
            m_addr = cur_ptr | AW'({fidx, 3'b000});
         end
         DS_CRD: begin
            m_req  = 1'b1;
            m_addr = src_q;
         end
         DS_CWR: begin
            m_req   = !w_full;
            m_we    = 1'b1;
            m_addr  = dst_q;
            m_wdata = data_q;
         end
         DS_SWR: begin
            m_req   = !w_full;
            m_we    = 1'b1;
            m_addr  = cur_ptr | AW'(OFF_STAT);
            m_wdata = stat_word;
         end
         default: ;
      endcase
   end

   assign accept      = m_req && m_ready;
   assign w_inc       = accept && m_we;
   assign swt_end     = (st == DS_SWT) && w_zero;
   assign cur_ld      = swt_end && !d_slv && !d_int;
   assign cur_nxt     = nxt_q;
   assign err_slv_set = ((st == DS_FWT) && m_rvalid && m_rerr) || (swt_end && d_slv);
   assign err_int_set = swt_end && d_int;
   assign idle        = (st == DS_IDLE);
   assign done        = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= DS_IDLE;
         fidx   <= '0;
         nxt_q  <= '0;
         src_q  <= '0;
         dst_q  <= '0;
         ctl_q  <= '0;
         left_q <= '0;
         data_q <= '0;
         d_slv  <= 1'b0;
         d_int  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            DS_IDLE: if (start) begin
               st    <= DS_FRD;
               fidx  <= '0;
               d_slv <= 1'b0;
               d_int <= 1'b0;
            end
            DS_FRD: if (m_ready) st <= DS_FWT;
            DS_FWT: if (m_rvalid) begin
               if (m_rerr) st <= DS_IDLE;
               else begin
                  unique case (fidx)
                     2'd0: nxt_q <= {m_rdata[AW-1:6], 6'b0};
                     2'd1: src_q <= m_rdata[AW-1:0];
                     2'd2: dst_q <= m_rdata[AW-1:0];
                     default: ctl_q <= m_rdata[LEN_W-1:0];
                  endcase
                  fidx <= fidx + 2'd1;
                  st   <= (fidx == 2'd3) ? DS_CHK : DS_FRD;
               end
            end
            DS_CHK: begin
               if (ctl_q[1:0] != 2'b00) begin
                  d_int <= 1'b1;
                  st    <= DS_DRN;
               end else if (ctl_q[LEN_W-1:2] == '0) begin
                  st <= DS_DRN;
               end else begin
                  left_q <= ctl_q[LEN_W-1:2];
                  st     <= DS_CRD;
               end
            end
            DS_CRD: if (m_ready) st <= DS_CWT;
            DS_CWT: if (m_rvalid) begin
               if (m_rerr) begin
                  d_slv <= 1'b1;
                  st    <= DS_DRN;
               end else begin
                  data_q <= m_rdata;
                  st     <= DS_CWR;
               end
            end
            DS_CWR: if (accept) begin
               src_q  <= src_q + AW'(4);
               dst_q  <= dst_q + AW'(4);
               left_q <= left_q - WN'(1);
               st     <= (left_q == WN'(1) || d_slv) ? DS_DRN : DS_CRD;
            end
            DS_DRN: if (w_zero) st <= DS_SWR;
            DS_SWR: if (accept) st <= DS_SWT;
            DS_SWT: if (w_zero) begin
               if (d_slv || d_int) st <= DS_IDLE;
               else if (cur_ptr == tail_ptr) begin
                  st     <= DS_IDLE;
                  done_q <= 1'b1;
               end else begin
                  st    <= DS_FRD;
                  fidx  <= '0;
                  d_slv <= 1'b0;
                  d_int <= 1'b0;
               end
            end
            default: st <= DS_IDLE;
         endcase
         if (m_bvalid && m_berr) d_slv <= 1'b1;
      end
   end

   // R5
   fetch_barrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (st == DS_FRD) && (fidx == 2'd0)) |-> w_zero);
   // R4
   stat_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (st == DS_SWR)) |-> w_zero);
   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_ready) |=> m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata));
   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> idle && !$past(idle));

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine #(
   parameter int AW      = 32,
   parameter int LEN_W   = 16,
   parameter int MAX_OUT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [5:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          m_req,
   output logic          m_we,
   output logic [AW-1:0] m_addr,
   output logic [31:0]   m_wdata,
   input  logic          m_ready,
   input  logic          m_rvalid,
   input  logic [31:0]   m_rdata,
   input  logic          m_rerr,
   input  logic          m_bvalid,
   input  logic          m_berr,
   output logic          idle,
   output logic          done
);
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("sgdma_engine: AW must lie in 8..32");
   end
   if (LEN_W < 13 || LEN_W > 31) begin : g_bad_len
      $error("sgdma_engine: LEN_W must lie in 13..31");
   end
   if (MAX_OUT < 1) begin : g_bad_out
      $error("sgdma_engine: MAX_OUT must be at least 1");
   end

   logic          start, cur_ld, err_slv_set, err_int_set;
   logic          w_zero, w_full, w_inc;
   logic [AW-1:0] cur_ptr, tail_ptr, cur_nxt;

   sgdma_regs #(.AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_idle(idle), .cur_ld(cur_ld), .cur_nxt(cur_nxt),
      .err_slv_set(err_slv_set), .err_int_set(err_int_set),
      .start(start), .cur_ptr(cur_ptr), .tail_ptr(tail_ptr)
   );

   sgdma_wtrack #(.MAX_OUT(MAX_OUT)) u_wtrack (
      .clk(clk), .rst_n(rst_n),
      .inc(w_inc), .dec(m_bvalid), .zero(w_zero), .full(w_full)
   );

   sgdma_ctrl #(.AW(AW), .LEN_W(LEN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cur_ptr(cur_ptr), .tail_ptr(tail_ptr),
      .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_ready(m_ready), .m_rvalid(m_rvalid), .m_rdata(m_rdata), .m_rerr(m_rerr),
      .m_bvalid(m_bvalid), .m_berr(m_berr),
      .w_zero(w_zero), .w_full(w_full), .w_inc(w_inc),
      .cur_ld(cur_ld), .cur_nxt(cur_nxt),
      .err_slv_set(err_slv_set), .err_int_set(err_int_set),
      .idle(idle), .done(done)
   );

endmodule

// File: tb/tb_sgdma_engine.sv
module tb_sgdma_engine;
   localparam int MAX_OUT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        m_req, m_we;
   logic [31:0] m_addr, m_wdata;
   logic        m_ready = 1'b0, m_rvalid = 1'b0, m_rerr = 1'b0;
   logic        m_bvalid = 1'b0, m_berr = 1'b0;
   logic [31:0] m_rdata = '0;
   logic        idle, done;

   always #5 clk = ~clk;

   sgdma_engine #(.AW(32), .LEN_W(16), .MAX_OUT(MAX_OUT)) dut (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_ready(m_ready), .m_rvalid(m_rvalid), .m_rdata(m_rdata), .m_rerr(m_rerr),
      .m_bvalid(m_bvalid), .m_berr(m_berr), .idle(idle), .done(done)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   // memory model state
   logic [31:0] mem [0:4095];
   bit          bq[$];
   bit          rd_pend = 1'b0, rd_err = 1'b0;
   int          rd_dly = 0;
   logic [31:0] rd_data = '0;
   int n_wr = 0, n_rd = 0, done_cnt = 0;
   int barrier_viol = 0, early_stat = 0, ovf = 0, bad_off = 0, watch_hits = 0;
   logic [31:0] watch_addr = 32'hFFFF_FFFF;

   function automatic bit is_err(logic [31:0] a);
      return a[13:8] == 6'h3F;
   endfunction

   function automatic logic [31:0] exp_stat(int len, int kind);
      if (kind == 1) return 32'h4000_0000;
      if (kind == 2) return 32'h2000_0000;
      return 32'h8000_0000 | 32'(len);
   endfunction

   always @(negedge clk) begin
      m_rvalid = 1'b0; m_bvalid = 1'b0; m_rerr = 1'b0; m_berr = 1'b0;
      if (done) done_cnt++;
      if (rd_pend) begin
         if (rd_dly == 0) begin
            m_rvalid = 1'b1; m_rdata = rd_data; m_rerr = rd_err; rd_pend = 1'b0;
         end else rd_dly--;
      end
      if (bq.size() > 0 && ($urandom % 3) != 0) begin
         m_berr = bq.pop_front(); m_bvalid = 1'b1;
      end
      m_ready = ($urandom % 4) != 0;
      if (rst_n && m_req && m_ready) begin
         if (m_we) begin
            n_wr++;
            if (m_addr < 32'h400 && m_addr[5:0] == 6'h1C && bq.size() != 0) early_stat++;
            if (is_err(m_addr)) bq.push_back(1'b1);
            else begin
               mem[m_addr[13:2]] = m_wdata;
               bq.push_back(1'b0);
            end
            if (bq.size() > MAX_OUT) ovf++;
         end else begin
            n_rd++;
            if (rd_pend) ovf++;
            if (m_addr < 32'h400 && m_addr[5:0] == 6'h00 && bq.size() != 0) barrier_viol++;
            if (m_addr < 32'h400 && m_addr[2]) bad_off++;
            if (m_addr == watch_addr) watch_hits++;
            rd_pend = 1'b1;
            rd_dly  = int'($urandom % 3);
            rd_err  = is_err(m_addr);
            rd_data = rd_err ? 32'hDEAD_BEEF : mem[m_addr[13:2]];
         end
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic reg_wr(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put_desc(logic [31:0] b, logic [31:0] nx, logic [31:0] s,
                           logic [31:0] dd, logic [31:0] len);
      mem[b[13:2]]       = nx;
      mem[b[13:2] + 1]   = 32'h1111_1111;
      mem[b[13:2] + 2]   = s;
      mem[b[13:2] + 3]   = 32'h1111_1111;
      mem[b[13:2] + 4]   = dd;
      mem[b[13:2] + 5]   = 32'h1111_1111;
      mem[b[13:2] + 6]   = len;
      mem[b[13:2] + 7]   = 32'h0BAD_0000;
   endtask

   task automatic wait_idle();
      int k = 0;
      while (!idle && k < 40000) begin
         @(negedge clk);
         k++;
      end
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic walk(logic [31:0] first, logic [31:0] last);
      done_cnt = 0;
      reg_wr(6'h08, first);
      reg_wr(6'h10, last);
      wait_idle();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL R7 watchdog: actual busy expected idle");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int wr0, rd0, bad;
      void'($urandom(32'd91357));
      for (int i = 0; i < 4096; i++) mem[i] = $urandom;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 idle", 32'(idle), 32'd1);
      chk("R1 m_req", 32'(m_req), 32'd0);
      reg_rd(6'h00, v); chk("R1 control", v, 32'h0);
      reg_rd(6'h04, v); chk("R1 status", v, 32'h1);
      reg_rd(6'h08, v); chk("R1 first ptr", v, 32'h0);
      reg_rd(6'h10, v); chk("R1 last ptr", v, 32'h0);

      // R2 pointer alignment
      reg_wr(6'h08, 32'h0000_0047);
      reg_rd(6'h08, v); chk("R2 first ptr masked", v, 32'h40);

      // R11 run bit clear: tail write ignored
      rd0 = n_rd;
      reg_wr(6'h10, 32'h40);
      repeat (10) @(negedge clk);
      chk("R11 no start without run", 32'(n_rd - rd0), 32'd0);
      chk("R11 still idle", 32'(idle), 32'd1);
      reg_wr(6'h00, 32'h1);

      // R3 R4 R6 R7 chain: 8 bytes, 4096 bytes, 0 bytes
      put_desc(32'h000, 32'h040, 32'h3000, 32'h3100, 32'd8);
      put_desc(32'h040, 32'h080, 32'h1000, 32'h2000, 32'd4096);
      put_desc(32'h080, 32'h0C0, 32'h3200, 32'h3300, 32'd0);
      mem[32'h3300 >> 2] = 32'h5A5A_5A5A;
      watch_addr = 32'h0C0;
      watch_hits = 0;
      wr0 = n_wr;
      done_cnt = 0;
      reg_wr(6'h08, 32'h000);
      reg_wr(6'h10, 32'h080);
      repeat (5) @(negedge clk);
      chk("R7 idle low while running", 32'(idle), 32'd0);
      reg_wr(6'h08, 32'h200);
      reg_wr(6'h10, 32'h300);
      wait_idle();
      bad = 0;
      for (int i = 0; i < 2; i++)
         if (mem[(32'h3100 >> 2) + i] !== mem[(32'h3000 >> 2) + i]) bad++;
      chk("R3 8-byte copy", 32'(bad), 32'd0);
      bad = 0;
      for (int i = 0; i < 1024; i++)
         if (mem[(32'h2000 >> 2) + i] !== mem[(32'h1000 >> 2) + i]) bad++;
      chk("R3 4096-byte copy", 32'(bad), 32'd0);
      chk("R3 zero count writes nothing", mem[32'h3300 >> 2], 32'h5A5A_5A5A);
      chk("R3 write count", 32'(n_wr - wr0), 32'd1029);
      chk("R4 status slot0", mem[32'h01C >> 2], exp_stat(8, 0));
      chk("R4 status slot1", mem[32'h05C >> 2], exp_stat(4096, 0));
      chk("R4 status slot2", mem[32'h09C >> 2], exp_stat(0, 0));
      chk("R6 no read past tail", 32'(watch_hits), 32'd0);
      reg_rd(6'h08, v); chk("R6 R11 first ptr is tail link", v, 32'h0C0);
      reg_rd(6'h10, v); chk("R11 tail write while busy ignored", v, 32'h080);
      chk("R7 one finish pulse", 32'(done_cnt), 32'd1);
      chk("R7 idle after walk", 32'(idle), 32'd1);

      // R3 R4 random single-slot copies
      for (int t = 0; t < 8; t++) begin
         int len, so, dof;
         len = 4 * (1 + int'($urandom % 64));
         so  = 4 * int'($urandom % 64);
         dof = 4 * int'($urandom % 64);
         put_desc(32'h100, 32'h140, 32'h1000 + 32'(so), 32'h2000 + 32'(dof), 32'(len));
         walk(32'h100, 32'h100);
         bad = 0;
         for (int i = 0; i < len / 4; i++)
            if (mem[((32'h2000 + 32'(dof)) >> 2) + 32'(i)] !== mem[((32'h1000 + 32'(so)) >> 2) + 32'(i)]) bad++;
         chk("R3 random copy", 32'(bad), 32'd0);
         chk("R4 random status", mem[32'h11C >> 2], exp_stat(len, 0));
         chk("R7 random finish pulse", 32'(done_cnt), 32'd1);
      end

      // R8 read error
      put_desc(32'h100, 32'h140, 32'h3F00, 32'h3400, 32'd16);
      put_desc(32'h140, 32'h180, 32'h1000, 32'h2000, 32'd16);
      watch_addr = 32'h140; watch_hits = 0;
      walk(32'h100, 32'h140);
      chk("R8 read error status word", mem[32'h11C >> 2], exp_stat(0, 1));
      reg_rd(6'h04, v); chk("R8 status reg", v, 32'h3);
      chk("R8 no further slot", 32'(watch_hits), 32'd0);
      chk("R8 no finish pulse", 32'(done_cnt), 32'd0);
      reg_rd(6'h08, v); chk("R8 first ptr kept", v, 32'h100);
      rd0 = n_rd;
      reg_wr(6'h10, 32'h100);
      repeat (10) @(negedge clk);
      chk("R11 no start with error set", 32'(n_rd - rd0), 32'd0);
      reg_wr(6'h00, 32'h3);
      reg_rd(6'h04, v); chk("R12 errors cleared", v, 32'h1);
      reg_rd(6'h00, v); chk("R12 run kept", v, 32'h1);

      // R8 write error
      put_desc(32'h100, 32'h140, 32'h3000, 32'h3FC0, 32'd32);
      walk(32'h100, 32'h100);
      chk("R8 write error status word", mem[32'h11C >> 2], exp_stat(0, 1));
      reg_rd(6'h04, v); chk("R8 status reg after write error", v, 32'h3);
      reg_wr(6'h00, 32'h3);

      // R9 bad count
      put_desc(32'h100, 32'h140, 32'h3000, 32'h3500, 32'd6);
      mem[32'h3500 >> 2] = 32'hC3C3_C3C3;
      wr0 = n_wr; rd0 = n_rd;
      walk(32'h100, 32'h100);
      chk("R9 status word", mem[32'h11C >> 2], exp_stat(0, 2));
      reg_rd(6'h04, v); chk("R9 status reg", v, 32'h5);
      chk("R9 only status written", 32'(n_wr - wr0), 32'd1);
      chk("R9 only field reads", 32'(n_rd - rd0), 32'd4);
      chk("R9 destination untouched", mem[32'h3500 >> 2], 32'hC3C3_C3C3);
      reg_wr(6'h00, 32'h3);

      // R10 field read error
      wr0 = n_wr;
      walk(32'h3F00, 32'h3F00);
      reg_rd(6'h04, v); chk("R10 status reg", v, 32'h3);
      chk("R10 no writes", 32'(n_wr - wr0), 32'd0);
      chk("R10 no finish pulse", 32'(done_cnt), 32'd0);
      reg_wr(6'h00, 32'h3);

      // global protocol observations
      chk("R2 no unused-offset reads", 32'(bad_off), 32'd0);
      chk("R5 barrier held", 32'(barrier_viol), 32'd0);
      chk("R4 status after data acks", 32'(early_stat), 32'd0);
      chk("R13 outstanding limits", 32'(ovf), 32'd0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule